// File: doc/BRIEF.md
# Layered Decoder Iteration Sequencer with Parity Convergence Test

This block paces a row-serial (layered) soft-decision LDPC decoder. After a start request it walks the layers of the base matrix one at a time. Each layer gets a read phase, a compute phase and a write phase, and the block raises a separate strobe for each phase together with the current layer index, so the message datapath knows what to do in every cycle. When the last layer has been written, the block spends one extra cycle counting the parity checks that the datapath reports as unsatisfied. It then decides whether to start another pass over the layers or to finish.

A run ends in one of two ways. The first is that the programmed iteration limit is reached. The second is that early termination is enabled and the parity test finds no unsatisfied check. When a run ends, the block drops busy and reports four results: whether the syndrome is clear, how many iterations were spent, and the syndrome weight saturated to 8 bits. It also captures the sign bits of the information positions as the decoded word. The firmware-facing register layer, the check-node arithmetic and the message memories sit outside this block.

Top module: `ldpc_iter_ctrl`

## Requirements
- R1: After reset, busy, converged, iter_used, synd_wt, dec_bits and all four phase strobes are 0.
- R2: A start pulse is accepted only while busy is 0. A start pulse during a run neither restarts the run nor changes its length.
- R3: Every accepted run is a sequence of iterations of 22 cycles each. In each iteration, layers 0 to 6 are visited in ascending order. Each layer takes 3 cycles, with ph_read, then ph_comp, then ph_write high, and layer_idx holds the layer for all 3 cycles. After the 7 layers comes one cycle with ph_check high. At most one strobe is high in any cycle.
- R4: max_iter and early_term_en are captured when start is accepted. Changing them during a run has no effect on that run.
- R5: With early termination enabled, busy falls right after the first check cycle in which no chk_fail bit is set.
- R6: With early termination disabled, a run lasts exactly the effective limit of iterations, whatever the syndrome.
- R7: The effective limit is max_iter, except that a max_iter of 0 counts as 1. A run never exceeds this limit, even when the syndrome never clears.
- R8: When a run ends, synd_wt becomes the number of set chk_fail bits (1 = unsatisfied check) seen in the final check cycle, saturated at 255. synd_wt is not updated at any other time.
- R9: When a run ends, converged becomes 1 if the final weight is zero and 0 otherwise.
- R10: When a run ends, iter_used becomes the number of iterations the run performed.
- R11: When a run ends, dec_bits takes the value of hd_sign from the final check cycle. Bit i of hd_sign is the sign of the posterior at codeword position i (1 = negative). dec_bits holds its value during a run and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a decode run (honoured only when idle) |
| max_iter | input | 5 | Iteration limit, 0 treated as 1 |
| early_term_en | input | 1 | Stop as soon as the syndrome is clear |
| chk_fail | input | 224 | Per-check parity result, 1 = unsatisfied |
| hd_sign | input | 32 | Posterior sign bits of the information positions |
| busy | output | 1 | A run is in progress |
| converged | output | 1 | Last run ended with a zero syndrome |
| iter_used | output | 5 | Iterations spent by the last run |
| synd_wt | output | 8 | Saturated unsatisfied-check count of the last run |
| dec_bits | output | 32 | Decoded information bits of the last run |
| layer_idx | output | 3 | Layer being processed |
| ph_read | output | 1 | Read phase strobe |
| ph_comp | output | 1 | Compute phase strobe |
| ph_write | output | 1 | Write phase strobe |
| ph_check | output | 1 | Syndrome evaluation strobe |

## Verification
The bound checker watches the layer and phase order on every cycle: the read, compute and write strobes must follow one another, the layer index must advance one step at a time, and the check strobe must come only after the last layer. It also checks that a run ends only out of a check cycle, that converged never appears with a nonzero weight, and that the decoded word stays still during a run. Run lengths, the point where early termination cuts in, the zero-limit case, weight saturation, and the fact that start and configuration changes are ignored mid-run all depend on the stimulus. The directed scenarios are what show these.

// File: rtl/ilc_pkg.sv
package ilc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LAYER = 2'd1,
      ST_CHECK = 2'd2
   } ctrl_state_t;

   typedef enum logic [1:0] {
      PH_RD  = 2'd0,
      PH_CMP = 2'd1,
      PH_WR  = 2'd2
   } phase_t;

endpackage

// File: rtl/ilc_phase_seq.sv
// Walks layer/phase positions; wraps to layer 0 read after the last write.
module ilc_phase_seq
   import ilc_pkg::*;
#(
   parameter int LAYERS  = 7,
   parameter int LAYER_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv,
   output logic [LAYER_W-1:0] layer,
   output phase_t             phase,
   output logic               last
);

   localparam logic [LAYER_W-1:0] TOP_LAYER = LAYER_W'(LAYERS - 1);

   assign last = (phase == PH_WR) && (layer == TOP_LAYER);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         layer <= '0;
         phase <= PH_RD;
      end else if (adv) begin
         unique case (phase)
            PH_RD:  phase <= PH_CMP;
            PH_CMP: phase <= PH_WR;
            PH_WR: begin
               phase <= PH_RD;
               layer <= last ? '0 : layer + 1'b1;
            end
            default: phase <= PH_RD;
         endcase
      end
   end

endmodule

// File: rtl/ilc_synd_weigher.sv
// Population count of unsatisfied checks, saturated when the count can overflow.
module ilc_synd_weigher #(
   parameter int NCHK = 224,
   parameter int WT_W = 8
) (
   input  logic [NCHK-1:0] fails,
   output logic [WT_W-1:0] weight,
   output logic            zero
);

   localparam int CNT_W = $clog2(NCHK + 1);

   logic [CNT_W-1:0] cnt;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < NCHK; i++) begin
         cnt = cnt + CNT_W'(fails[i]);
      end
   end

   assign zero = ~|fails;

   generate
      if (CNT_W > WT_W) begin : g_sat
         localparam logic [CNT_W-1:0] CAP = CNT_W'((2 ** WT_W) - 1);
         assign weight = (cnt > CAP) ? {WT_W{1'b1}} : cnt[WT_W-1:0];
      end else begin : g_fit
         assign weight = WT_W'(cnt);
      end
   endgenerate

endmodule

// File: rtl/ilc_iter_limit.sv
// Captures run configuration and tracks completed iterations against the limit.
module ilc_iter_limit #(
   parameter int ITER_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ITER_W-1:0] max_in,
   input  logic              et_in,
   input  logic              step,
   output logic              et_en,
   output logic              at_limit,
   output logic [ITER_W-1:0] count_next
);

   logic [ITER_W-1:0] lim_q;
   logic [ITER_W-1:0] done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lim_q  <= ITER_W'(1);
         et_en  <= 1'b0;
         done_q <= '0;
      end else if (load) begin
         lim_q  <= (max_in == '0) ? ITER_W'(1) : max_in;
         et_en  <= et_in;
         done_q <= '0;
      end else if (step) begin
         done_q <= count_next;
      end
   end

   assign count_next = done_q + 1'b1;
   assign at_limit   = (count_next >= lim_q);

endmodule

// File: rtl/ldpc_iter_ctrl.sv
module ldpc_iter_ctrl
   import ilc_pkg::*;
#(
   parameter int LAYERS    = 7,
   parameter int LIFT      = 32,
   parameter int INFO_BITS = 32,
   parameter int ITER_W    = 5,
   parameter int WT_W      = 8,
   localparam int NCHK     = LAYERS * LIFT,
   localparam int LAYER_W  = (LAYERS > 1) ? $clog2(LAYERS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [ITER_W-1:0]    max_iter,
   input  logic                 early_term_en,
   input  logic [NCHK-1:0]      chk_fail,
   input  logic [INFO_BITS-1:0] hd_sign,
   output logic                 busy,
   output logic                 converged,
   output logic [ITER_W-1:0]    iter_used,
   output logic [WT_W-1:0]      synd_wt,
   output logic [INFO_BITS-1:0] dec_bits,
   output logic [LAYER_W-1:0]   layer_idx,
   output logic                 ph_read,
   output logic                 ph_comp,
   output logic                 ph_write,
   output logic                 ph_check
);

   generate
      if (LAYERS < 2) begin : g_bad_layers
         $error("LAYERS must be at least 2");
      end
      if (LIFT < 1 || INFO_BITS < 1) begin : g_bad_size
         $error("LIFT and INFO_BITS must be positive");
      end
      if (INFO_BITS > NCHK * 8) begin : g_bad_info
         $error("INFO_BITS exceeds the code length");
      end
      if (ITER_W < 1 || WT_W < 1) begin : g_bad_width
         $error("ITER_W and WT_W must be positive");
      end
   endgenerate

   ctrl_state_t state_q, state_d;
   phase_t      phase;
   logic        layer_last;
   logic        load, step, finish;
   logic        et_en, at_limit, synd_zero;
   logic [ITER_W-1:0] count_next;
   logic [WT_W-1:0]   weight;

   ilc_phase_seq #(
      .LAYERS  (LAYERS),
      .LAYER_W (LAYER_W)
   ) i_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (state_q == ST_LAYER),
      .layer (layer_idx),
      .phase (phase),
      .last  (layer_last)
   );

   ilc_synd_weigher #(
      .NCHK (NCHK),
      .WT_W (WT_W)
   ) i_weigh (
      .fails  (chk_fail),
      .weight (weight),
      .zero   (synd_zero)
   );

   ilc_iter_limit #(
      .ITER_W (ITER_W)
   ) i_limit (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .max_in     (max_iter),
      .et_in      (early_term_en),
      .step       (step),
      .et_en      (et_en),
      .at_limit   (at_limit),
      .count_next (count_next)
   );

   assign load   = (state_q == ST_IDLE) && start;
   assign step   = (state_q == ST_CHECK);
   assign finish = at_limit || (et_en && synd_zero);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start) state_d = ST_LAYER;
         ST_LAYER: if (layer_last) state_d = ST_CHECK;
         ST_CHECK: state_d = finish ? ST_IDLE : ST_LAYER;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         converged <= 1'b0;
         iter_used <= '0;
         synd_wt   <= '0;
         dec_bits  <= '0;
      end else begin
         state_q <= state_d;
         if (step && finish) begin
            converged <= synd_zero;
            iter_used <= count_next;
            synd_wt   <= weight;
            dec_bits  <= hd_sign;
         end
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign ph_read  = (state_q == ST_LAYER) && (phase == PH_RD);
   assign ph_comp  = (state_q == ST_LAYER) && (phase == PH_CMP);
   assign ph_write = (state_q == ST_LAYER) && (phase == PH_WR);
   assign ph_check = (state_q == ST_CHECK);

endmodule

// File: rtl/ilc_checker.sv
module ilc_checker #(
   parameter int LAYERS    = 7,
   parameter int LAYER_W   = 3,
   parameter int ITER_W    = 5,
   parameter int WT_W      = 8,
   parameter int INFO_BITS = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 busy,
   input logic                 converged,
   input logic [ITER_W-1:0]    iter_used,
   input logic [WT_W-1:0]      synd_wt,
   input logic [INFO_BITS-1:0] dec_bits,
   input logic [LAYER_W-1:0]   layer_idx,
   input logic                 ph_read,
   input logic                 ph_comp,
   input logic                 ph_write,
   input logic                 ph_check
);

   localparam logic [LAYER_W-1:0] TOP_LAYER = LAYER_W'(LAYERS - 1);

   // R3
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ph_read, ph_comp, ph_write, ph_check}));

   // R3
   read_to_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_read |=> ph_comp && $stable(layer_idx));

   // R3
   comp_to_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_comp |=> ph_write && $stable(layer_idx));

   // R3
   layer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_read || ph_comp || ph_write) |-> (layer_idx <= TOP_LAYER));

   // R3
   layer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_write && layer_idx != TOP_LAYER) |=>
         ph_read && (layer_idx == LAYER_W'($past(layer_idx) + 1'b1)));

   // R3
   check_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_write && layer_idx == TOP_LAYER) |=> ph_check);

   // R3
   check_then_layer0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_check |=> (!busy || (ph_read && layer_idx == '0)));

   // R2
   busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy == (ph_read || ph_comp || ph_write || ph_check));

   // R7
   end_from_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(ph_check));

   // R10
   iter_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (iter_used != '0));

   // R9
   conv_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      converged |-> (synd_wt == '0));

   // R11
   dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $stable(dec_bits));

endmodule

bind ldpc_iter_ctrl ilc_checker #(
   .LAYERS    (LAYERS),
   .LAYER_W   (LAYER_W),
   .ITER_W    (ITER_W),
   .WT_W      (WT_W),
   .INFO_BITS (INFO_BITS)
) i_ilc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .converged (converged),
   .iter_used (iter_used),
   .synd_wt   (synd_wt),
   .dec_bits  (dec_bits),
   .layer_idx (layer_idx),
   .ph_read   (ph_read),
   .ph_comp   (ph_comp),
   .ph_write  (ph_write),
   .ph_check  (ph_check)
);

// File: tb/test_ldpc_iter_ctrl.sv
module test_ldpc_iter_ctrl;

   localparam int LAYERS = 7;
   localparam int LIFT   = 40;
   localparam int NCHK   = LAYERS * LIFT;
   localparam int INFO   = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [4:0]      max_iter = '0;
   logic            early_term_en = 1'b0;
   logic [NCHK-1:0] chk_fail = '0;
   logic [INFO-1:0] hd_sign = '0;
   logic            busy, converged;
   logic [4:0]      iter_used;
   logic [7:0]      synd_wt;
   logic [INFO-1:0] dec_bits;
   logic [2:0]      layer_idx;
   logic            ph_read, ph_comp, ph_write, ph_check;

   int n_checks = 0;
   int n_fail   = 0;
   int sched_bad;

   always #5 clk = ~clk;

   ldpc_iter_ctrl #(
      .LAYERS    (LAYERS),
      .LIFT      (LIFT),
      .INFO_BITS (INFO),
      .ITER_W    (5),
      .WT_W      (8)
   ) i_ldpc_iter_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .max_iter      (max_iter),
      .early_term_en (early_term_en),
      .chk_fail      (chk_fail),
      .hd_sign       (hd_sign),
      .busy          (busy),
      .converged     (converged),
      .iter_used     (iter_used),
      .synd_wt       (synd_wt),
      .dec_bits      (dec_bits),
      .layer_idx     (layer_idx),
      .ph_read       (ph_read),
      .ph_comp       (ph_comp),
      .ph_write      (ph_write),
      .ph_check      (ph_check)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [NCHK-1:0] pat(input int w);
      logic [NCHK-1:0] p;
      for (int i = 0; i < NCHK; i++) p[i] = (i < w);
      return p;
   endfunction

   // Runs one decode; the syndrome has weight w for the first nfail checks, then clears.
   task automatic run_decode(input int mx, input bit et, input int nfail, input int w,
                             input bit poke, output int cyc);
      int seen = 0;
      cyc = 0;
      sched_bad = 0;
      @(negedge clk);
      chk_fail = (nfail > 0) ? pat(w) : '0;
      max_iter = mx[4:0];
      early_term_en = et;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy && cyc < 5000) begin
         if (cyc < 21) begin
            if (layer_idx != 3'(cyc / 3) ||
                {ph_read, ph_comp, ph_write, ph_check} != (4'b1000 >> (cyc % 3)))
               sched_bad++;
         end else if (cyc == 21) begin
            if ({ph_read, ph_comp, ph_write, ph_check} != 4'b0001) sched_bad++;
         end
         if (ph_check) seen++;
         else chk_fail = (seen < nfail) ? pat(w) : '0;
         if (poke && cyc == 10) begin
            start = 1'b1;
            max_iter = 5'd1;
            early_term_en = 1'b1;
         end else if (poke && cyc == 11) begin
            start = 1'b0;
         end
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk(busy == 1'b0, "R1", "busy", busy, 0);
      chk(converged == 1'b0, "R1", "converged", converged, 0);
      chk(iter_used == 5'd0, "R1", "iter_used", iter_used, 0);
      chk(synd_wt == 8'd0, "R1", "synd_wt", synd_wt, 0);
      chk(dec_bits == '0, "R1", "dec_bits", dec_bits, 0);
      chk({ph_read, ph_comp, ph_write, ph_check} == 4'b0, "R1", "strobes",
          {ph_read, ph_comp, ph_write, ph_check}, 0);
   endtask

   task automatic t_schedule();
      int c;
      run_decode(2, 1'b0, 0, 0, 1'b0, c);
      chk(sched_bad == 0, "R3", "layer/phase order errors", sched_bad, 0);
      chk(c == 44, "R3", "cycles for 2 iterations", c, 44);
   endtask

   task automatic t_early();
      int c;
      run_decode(30, 1'b1, 2, 5, 1'b0, c);
      chk(c == 66, "R5", "early stop cycles", c, 66);
      chk(iter_used == 5'd3, "R10", "iter_used early", iter_used, 3);
      chk(converged == 1'b1, "R9", "converged early", converged, 1);
      chk(synd_wt == 8'd0, "R8", "weight early", synd_wt, 0);
   endtask

   task automatic t_no_early();
      int c;
      run_decode(4, 1'b0, 1, 3, 1'b0, c);
      chk(c == 88, "R6", "full run cycles", c, 88);
      chk(iter_used == 5'd4, "R10", "iter_used full", iter_used, 4);
      chk(converged == 1'b1, "R9", "converged full", converged, 1);
   endtask

   task automatic t_limit();
      int c;
      run_decode(3, 1'b1, 99, 9, 1'b0, c);
      chk(c == 66, "R7", "limit cycles", c, 66);
      chk(converged == 1'b0, "R9", "not converged", converged, 0);
      chk(synd_wt == 8'd9, "R8", "weight 9", synd_wt, 9);
      chk(iter_used == 5'd3, "R10", "iter_used limit", iter_used, 3);
   endtask

   task automatic t_zero_max();
      int c;
      run_decode(0, 1'b0, 99, 2, 1'b0, c);
      chk(c == 22, "R7", "max 0 cycles", c, 22);
      chk(iter_used == 5'd1, "R7", "max 0 iter_used", iter_used, 1);
   endtask

   task automatic t_saturate();
      int c;
      run_decode(1, 1'b1, 99, NCHK, 1'b0, c);
      chk(synd_wt == 8'd255, "R8", "all checks fail", synd_wt, 255);
      run_decode(1, 1'b1, 99, 255, 1'b0, c);
      chk(synd_wt == 8'd255, "R8", "weight 255", synd_wt, 255);
      run_decode(1, 1'b1, 99, 254, 1'b0, c);
      chk(synd_wt == 8'd254, "R8", "weight 254", synd_wt, 254);
      // R8: weight held while idle even as chk_fail changes
      chk_fail = pat(17);
      repeat (3) @(negedge clk);
      chk(synd_wt == 8'd254, "R8", "idle weight hold", synd_wt, 254);
   endtask

   task automatic t_ignore_start();
      int c;
      run_decode(3, 1'b0, 0, 0, 1'b1, c);
      chk(c == 66, "R2", "run length with mid-run start", c, 66);
      chk(iter_used == 5'd3, "R4", "captured limit", iter_used, 3);
   endtask

   task automatic t_decoded();
      int c;
      hd_sign = 32'hA5C3_0F91;
      run_decode(2, 1'b1, 99, 4, 1'b0, c);
      chk(dec_bits == 32'hA5C3_0F91, "R11", "dec_bits latch", dec_bits, 32'hA5C3_0F91);
      hd_sign = 32'h1234_5678;
      repeat (4) @(negedge clk);
      chk(dec_bits == 32'hA5C3_0F91, "R11", "dec_bits hold idle", dec_bits, 32'hA5C3_0F91);
      run_decode(1, 1'b1, 0, 0, 1'b0, c);
      chk(dec_bits == 32'h1234_5678, "R11", "dec_bits new run", dec_bits, 32'h1234_5678);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_schedule();
      t_early();
      t_no_early();
      t_limit();
      t_zero_max();
      t_saturate();
      t_ignore_start();
      t_decoded();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule